// File: doc/BRIEF.md
# Register Bank with Arithmetic Unit

This block holds eight 16-bit working registers and the arithmetic unit that operates on them. It sits in the execute path of a small processor. Each cycle the control logic picks two source registers, an arithmetic operation, the second operand (a register or a zero-extended 7-bit constant), and the source of the value to write back. That source is the arithmetic result, the constant, or a word returned from data memory. The write lands on the rising clock edge. Both read ports are combinational.

Register 0 is a constant zero, and writes aimed at it are dropped. A zero flag follows every write-back value. A carry flag records the carry out of bit 15, or the borrow, but only when an arithmetic result is written back. The block also exposes the low 7 bits of the port-A value as a data-memory address, and an equality signal between the two read ports for compare-and-branch decisions.

Top module: `regbank_alu`

## Requirements
- R1: While `rst` is high at a rising edge, all registers clear to zero, and `z_flag` and `c_flag` clear to 0.
- R2: Selecting register 0 on either read port always gives zero. A write with `wr_sel` = 0 changes no register.
- R3: When `wr_en` is high at a rising edge, the write-back value is stored into register `wr_sel` (1 to 7). When `wr_en` is low, no register changes. `rd_a_data` and `rd_b_data` combinationally show the registers chosen by `rd_a_sel` and `rd_b_sel`.
- R4: `wb_src` chooses the write-back value: 1 gives the zero-extended `imm`, 2 gives `mem_rdata`, and 0 or 3 give the arithmetic result.
- R5: `alu_op` 0 computes A+B, 1 computes A-B, 2 computes A+1 and 3 computes A-1. All four wrap modulo 2^16.
- R6: `alu_op` 4 passes operand B through. `alu_op` 5 gives 1 if A < B as unsigned numbers, else 0. Codes 6 and 7 give 0.
- R7: Operand A is always `rd_a_data`. Operand B is the zero-extended `imm` when `op_b_imm` is 1, else `rd_b_data`.
- R8: On every write with `wr_en` high (including one addressed to register 0), `z_flag` becomes 1 if the write-back value is zero, else 0. Without a write, `z_flag` holds.
- R9: `c_flag` loads only on a write whose `wb_src` selects the arithmetic result and whose op is 0 to 3. It takes the carry out of bit 15 for add and increment, and the borrow (A < B unsigned, or A = 0 for decrement) for subtract and decrement. Otherwise it holds.
- R10: `mem_addr` equals bits 6..0 of `rd_a_data`.
- R11: `eq_ab` is 1 exactly when `rd_a_data` equals `rd_b_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write-back enable |
| wr_sel | input | 3 | Destination register |
| rd_a_sel | input | 3 | Port A register select |
| rd_b_sel | input | 3 | Port B register select |
| alu_op | input | 3 | Arithmetic operation code |
| op_b_imm | input | 1 | Use immediate as operand B |
| wb_src | input | 2 | Write-back source select |
| imm | input | 7 | Unsigned constant |
| mem_rdata | input | 16 | Word read from data memory |
| rd_a_data | output | 16 | Port A value |
| rd_b_data | output | 16 | Port B value |
| mem_addr | output | 7 | Data memory address from port A |
| eq_ab | output | 1 | Ports A and B are equal |
| z_flag | output | 1 | Zero flag |
| c_flag | output | 1 | Carry/borrow flag |

## Verification
Several properties are checked on every cycle. Register 0 reads as zero. A write lands in the addressed entry. An idle cycle leaves the bank untouched. The zero flag tracks each write-back and holds between writes. The carry flag holds whenever no arithmetic result is written. The compare result is 0 or 1. Only the bench scenarios can show the arithmetic values themselves: wrap at 0xFFFF and at zero, carry and borrow polarity, immediate zero-extension, the source selection codes, and the address and equality outputs against a reference model.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

    localparam int DATA_W  = 16;
    localparam int REG_CNT = 8;
    localparam int IMM_W   = 7;
    localparam int MADDR_W = 7;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_INC = 3'd2,
        ALU_DEC = 3'd3,
        ALU_MOV = 3'd4,
        ALU_SLT = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'd0,
        WB_IMM  = 2'd1,
        WB_MEM  = 2'd2,
        WB_ALT  = 2'd3
    } wb_src_e;

    // True for the operations whose carry/borrow may reach the C flag
    function automatic logic op_is_arith(input logic [2:0] code);
        return (code == ALU_ADD) || (code == ALU_SUB) ||
               (code == ALU_INC) || (code == ALU_DEC);
    endfunction

endpackage

// File: rtl/regalu_regfile.sv
module regalu_regfile
    import regalu_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = REG_CNT,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [W-1:0]  wdata,
    input  logic [SW-1:0] asel,
    input  logic [SW-1:0] bsel,
    output logic [W-1:0]  adata,
    output logic [W-1:0]  bdata
);

    logic [N-1:0][W-1:0] bank;

    for (genvar g = 0; g < N; g++) begin : g_entry
        if (g == 0) begin : g_zero
            assign bank[g] = '0;
        end else begin : g_store
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (we && (wsel == SW'(g)))
                    q <= wdata;
            end
            assign bank[g] = q;
        end
    end

    assign adata = bank[asel];
    assign bdata = bank[bsel];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && wsel != '0) |=> bank[$past(wsel)] == $past(wdata)); // R3

    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        !we |=> bank == $past(bank)); // R3

endmodule

// File: rtl/regalu_alu.sv
module regalu_alu
    import regalu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         cout,
    output logic         carry_op
);

    logic [W:0] ext;
    logic [W:0] a_x;
    logic [W:0] b_x;

    assign a_x = {1'b0, a};
    assign b_x = {1'b0, b};

    always_comb begin
        ext = '0;
        case (op)
            ALU_ADD: ext = a_x + b_x;
            ALU_SUB: ext = a_x - b_x;
            ALU_INC: ext = a_x + (W+1)'(1);
            ALU_DEC: ext = a_x - (W+1)'(1);
            ALU_MOV: ext = b_x;
            ALU_SLT: ext = (a < b) ? (W+1)'(1) : '0;
            default: ext = '0;
        endcase
    end

    assign y        = ext[W-1:0];
    assign cout     = ext[W];
    assign carry_op = op_is_arith(op);

endmodule

// File: rtl/regbank_alu.sv
module regbank_alu
    import regalu_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int NR  = REG_CNT,
    parameter int IW  = IMM_W,
    parameter int AW  = MADDR_W,
    localparam int SW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [SW-1:0] rd_a_sel,
    input  logic [SW-1:0] rd_b_sel,
    input  logic [2:0]    alu_op,
    input  logic          op_b_imm,
    input  logic [1:0]    wb_src,
    input  logic [IW-1:0] imm,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] rd_a_data,
    output logic [DW-1:0] rd_b_data,
    output logic [AW-1:0] mem_addr,
    output logic          eq_ab,
    output logic          z_flag,
    output logic          c_flag
);

    logic [DW-1:0] imm_x;
    logic [DW-1:0] opnd_b;
    logic [DW-1:0] alu_y;
    logic          alu_cout;
    logic          alu_arith;
    logic [DW-1:0] wb_data;
    logic          wb_from_alu;
    logic          c_load;

    assign imm_x = {{(DW-IW){1'b0}}, imm};

    regalu_regfile #(.W(DW), .N(NR)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .wsel  (wr_sel),
        .wdata (wb_data),
        .asel  (rd_a_sel),
        .bsel  (rd_b_sel),
        .adata (rd_a_data),
        .bdata (rd_b_data)
    );

    assign opnd_b = op_b_imm ? imm_x : rd_b_data;

    regalu_alu #(.W(DW)) u_alu (
        .op       (alu_op),
        .a        (rd_a_data),
        .b        (opnd_b),
        .y        (alu_y),
        .cout     (alu_cout),
        .carry_op (alu_arith)
    );

    always_comb begin
        case (wb_src)
            WB_IMM:  wb_data = imm_x;
            WB_MEM:  wb_data = mem_rdata;
            default: wb_data = alu_y;
        endcase
    end

    assign wb_from_alu = (wb_src == WB_ALU) || (wb_src == WB_ALT);
    assign c_load      = wr_en && wb_from_alu && alu_arith;

    always_ff @(posedge clk) begin
        if (rst) begin
            z_flag <= 1'b0;
            c_flag <= 1'b0;
        end else begin
            if (wr_en)
                z_flag <= (wb_data == '0);
            if (c_load)
                c_flag <= alu_cout;
        end
    end

    assign mem_addr = rd_a_data[AW-1:0];
    assign eq_ab    = (rd_a_data == rd_b_data);

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_a_sel == '0) |-> (rd_a_data == '0)); // R2

    AST_Z_FOLLOWS_WB: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> z_flag == ($past(wb_data) == '0)); // R8

    AST_Z_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(z_flag)); // R8

    AST_C_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !c_load |=> $stable(c_flag)); // R9

    AST_SLT_BOOL: assert property (@(posedge clk) disable iff (rst)
        (alu_op == ALU_SLT) |-> (alu_y <= DW'(1))); // R6

endmodule

// File: tb/regbank_alu_bench.sv
module regbank_alu_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_sel, rd_a_sel, rd_b_sel, alu_op;
    logic        op_b_imm;
    logic [1:0]  wb_src;
    logic [6:0]  imm;
    logic [15:0] mem_rdata;
    logic [15:0] rd_a_data, rd_b_data;
    logic [6:0]  mem_addr;
    logic        eq_ab, z_flag, c_flag;

    int checks = 0;
    int failures = 0;

    logic [15:0] m_regs [8];
    logic        m_z, m_c;

    always #10 clk = ~clk;

    regbank_alu u_regbank_alu (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .rd_a_sel(rd_a_sel), .rd_b_sel(rd_b_sel), .alu_op(alu_op),
        .op_b_imm(op_b_imm), .wb_src(wb_src), .imm(imm),
        .mem_rdata(mem_rdata), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .mem_addr(mem_addr), .eq_ab(eq_ab), .z_flag(z_flag), .c_flag(c_flag)
    );

    // {arith, carry, value}
    function automatic logic [17:0] ref_alu(input logic [2:0] op,
                                            input logic [15:0] a,
                                            input logic [15:0] b);
        logic [16:0] s;
        logic        ar;
        ar = 1'b1;
        case (op)
            3'd0: s = {1'b0, a} + {1'b0, b};
            3'd1: s = {1'b0, a} - {1'b0, b};
            3'd2: s = {1'b0, a} + 17'd1;
            3'd3: s = {1'b0, a} - 17'd1;
            3'd4: begin s = {1'b0, b}; ar = 1'b0; end
            3'd5: begin s = (a < b) ? 17'd1 : 17'd0; ar = 1'b0; end
            default: begin s = 17'd0; ar = 1'b0; end
        endcase
        return {ar, s};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic we, input logic [2:0] ws,
                          input logic [2:0] as, input logic [2:0] bs,
                          input logic [2:0] op, input logic [1:0] src,
                          input logic bimm, input logic [6:0] iv,
                          input logic [15:0] md);
        logic [15:0] ea, eb, ob, wv;
        logic [17:0] r;
        @(negedge clk);
        wr_en = we; wr_sel = ws; rd_a_sel = as; rd_b_sel = bs;
        alu_op = op; wb_src = src; op_b_imm = bimm; imm = iv; mem_rdata = md;
        #1;
        ea = m_regs[as];
        eb = m_regs[bs];
        check("R3 port A", rd_a_data, ea);
        check("R3 port B", rd_b_data, eb);
        check("R10 address", {9'b0, mem_addr}, {9'b0, ea[6:0]});
        check("R11 equal", {15'b0, eq_ab}, {15'b0, ea == eb});
        ob = bimm ? {9'b0, iv} : eb;
        r = ref_alu(op, ea, ob);
        case (src)
            2'd1:    wv = {9'b0, iv};
            2'd2:    wv = md;
            default: wv = r[15:0];
        endcase
        @(posedge clk);
        #1;
        if (we) begin
            if (ws != 3'd0) m_regs[ws] = wv;
            m_z = (wv == 16'd0);
            if ((src == 2'd0 || src == 2'd3) && r[17]) m_c = r[16];
        end
        wr_en = 1'b0;
        rd_a_sel = ws;
        #1;
        check(tag, rd_a_data, m_regs[ws]);
        check("R8 zero flag", {15'b0, z_flag}, {15'b0, m_z});
        check("R9 carry flag", {15'b0, c_flag}, {15'b0, m_c});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; rd_a_sel = '0; rd_b_sel = '0;
        alu_op = '0; op_b_imm = 1'b0; wb_src = '0; imm = '0; mem_rdata = '0;
        for (int i = 0; i < 8; i++) m_regs[i] = 16'd0;
        m_z = 1'b0; m_c = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int i = 0; i < 8; i++) begin
            rd_a_sel = 3'(i); rd_b_sel = 3'(i);
            #1;
            check("R1 reset port A", rd_a_data, 16'd0);
            check("R1 reset port B", rd_b_data, 16'd0);
        end
        check("R1 reset Z", {15'b0, z_flag}, 16'd0);
        check("R1 reset C", {15'b0, c_flag}, 16'd0);

        // Directed corner cases
        run_op("R2 write to R0 dropped", 1, 3'd0, 0, 0, 3'd0, 2'd1, 0, 7'd5, 16'h0);
        run_op("R4 immediate source", 1, 3'd1, 0, 0, 3'd0, 2'd1, 0, 7'h7F, 16'h0);
        run_op("R4 memory source", 1, 3'd2, 0, 0, 3'd0, 2'd2, 0, 7'h0, 16'hFFFF);
        run_op("R5 add with carry", 1, 3'd3, 3'd2, 3'd1, 3'd0, 2'd0, 0, 7'h0, 16'h0);
        run_op("R5 increment wraps", 1, 3'd4, 3'd2, 3'd0, 3'd2, 2'd0, 0, 7'h0, 16'h0);
        run_op("R5 subtract to zero", 1, 3'd5, 3'd1, 3'd1, 3'd1, 2'd0, 0, 7'h0, 16'h0);
        run_op("R5 decrement of zero", 1, 3'd5, 3'd0, 3'd0, 3'd3, 2'd0, 0, 7'h0, 16'h0);
        run_op("R6 move keeps carry", 1, 3'd6, 3'd0, 3'd1, 3'd4, 2'd0, 0, 7'h0, 16'h0);
        run_op("R5 subtract with borrow", 1, 3'd6, 3'd1, 3'd2, 3'd1, 2'd3, 0, 7'h0, 16'h0);
        run_op("R6 less than true", 1, 3'd7, 3'd1, 3'd2, 3'd5, 2'd0, 0, 7'h0, 16'h0);
        run_op("R6 less than false", 1, 3'd7, 3'd2, 3'd1, 3'd5, 2'd0, 0, 7'h0, 16'h0);
        run_op("R7 immediate operand", 1, 3'd6, 3'd1, 3'd2, 3'd0, 2'd0, 1, 7'h01, 16'h0);
        run_op("R9 immediate source holds C", 1, 3'd7, 3'd2, 3'd2, 3'd0, 2'd1, 0, 7'h00, 16'h0);
        run_op("R3 idle cycle keeps", 0, 3'd3, 3'd1, 3'd1, 3'd0, 2'd1, 0, 7'h11, 16'h1234);
        run_op("R6 unused code gives zero", 1, 3'd3, 3'd2, 3'd1, 3'd6, 2'd0, 0, 7'h0, 16'h0);
        run_op("R11 equal registers", 1, 3'd3, 3'd4, 3'd0, 3'd4, 2'd0, 0, 7'h0, 16'h0);

        // Constrained random traffic
        for (int n = 0; n < 600; n++) begin
            logic [15:0] rv;
            rv = 16'($urandom());
            if (rv[1:0] == 2'd0) rv = 16'hFFFF;
            run_op("R5 random write-back", 1'($urandom_range(0, 3) != 0),
                   3'($urandom()), 3'($urandom()), 3'($urandom()), 3'($urandom()),
                   2'($urandom()), 1'($urandom()), 7'($urandom()), rv);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule